// File: doc/BRIEF.md
# Outstanding Read-Miss Admission Tracker

This block sits between the cache miss sources and the system bus request path. It decides, cycle by cycle, whether a new read-miss request may go out to the bus, given what is already in flight. Three sources can ask for a slot: instruction fetch, load/prefetch and store. Each request also carries a type: read-shared, read-own, read-to-discard (or non-cacheable block read), read-shared-always, or non-cacheable single read.

The block keeps a small table of outstanding entries. A granted request takes the lowest free entry, and the entry index goes back to the requester with the grant. That index later returns on the completion input, which frees the entry. Admission applies a shared cap across all entries. On top of that cap it applies per-type limits and per-source limits. It also keeps a non-cacheable single read apart from every other request. A request that breaks any limit is stalled with no grant and must be held until capacity is freed.

Top module: `readMissAdmit`

## Requirements
- R1: No more than NUM_ENTRIES (default 3) requests are outstanding at once. A request that finds the table full is not granted.
- R2: Read-shared (kind 0) and read-own (kind 1) requests are limited together only by MAX_RDSO (default 3). With the defaults, three of them in any mix can be outstanding at once.
- R3: At most MAX_DISCARD (default 1) read-to-discard / non-cacheable block read requests (kind 2) are outstanding. Other kinds are still admitted while one is in flight.
- R4: At most MAX_ALWAYS (default 1) read-shared-always requests (kind 3) are outstanding.
- R5: Per-source limits apply. Instruction fetch (source bit 0) may have at most 1 outstanding, store (bit 2) at most 1, and load/prefetch (bit 1) at most 3.
- R6: A non-cacheable single read (kind 4) is granted only when the table is empty. While it is outstanding, no request of any kind or source is granted.
- R7: The grant is combinational in the request cycle, and at most one grant bit is set per cycle. Among requesters that are eligible, instruction fetch wins over load, and load wins over store. An ineligible requester is passed over in favour of the next eligible one.
- R8: grantIdx gives the lowest-numbered free entry. A completion (cplValid with cplIdx) frees that entry. A completion that names an empty entry changes nothing.
- R9: When a completion and a grant fall in the same cycle, both take effect. Admission in that cycle uses the occupancy from before the completion, so the freed capacity can be used from the next cycle.
- R10: Request kinds 5 to 7 are reserved and are never granted.
- R11: After reset the table is empty, and no grant is raised without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 3 | Request per source: bit 0 instruction fetch, bit 1 load/prefetch, bit 2 store |
| reqKind | input | 9 | Request kind, 3 bits per source; source s uses bits [3s+2:3s] |
| cplValid | input | 1 | Completion strobe |
| cplIdx | input | IDXW (2) | Entry freed by the completion |
| grant | output | 3 | One-hot grant to the winning source |
| grantIdx | output | IDXW (2) | Entry index given to the granted request |

## Verification
The bench builds the block with its default parameters. These are a shared cap of three, limits of one for discard, shared-always, fetch and store, and three for load and for shared/own. With these values every limit can be hit within two to four requests, so each stall boundary is reached directly. The small table also lets the same-cycle completion-and-grant case be set up against both a full and a partly full table. Lowest-free-index reuse is checked after out-of-order completions.

// File: rtl/missAdmitPkg.sv
package missAdmitPkg;

  localparam int NUM_SRC    = 3;
  localparam int SRC_IFETCH = 0;
  localparam int SRC_LOAD   = 1;
  localparam int SRC_STORE  = 2;
  localparam int NUM_KIND   = 5;
  localparam int IDX_MAX_W  = 4;

  typedef enum logic [2:0] {
    KIND_SHARED   = 3'd0,
    KIND_OWN      = 3'd1,
    KIND_DISCARD  = 3'd2,
    KIND_ALWAYS   = 3'd3,
    KIND_NCSINGLE = 3'd4
  } reqKindE;

  // strobes from control to the entry table
  typedef struct packed {
    logic                 alloc;
    logic [IDX_MAX_W-1:0] allocIdx;
    logic [1:0]           allocSrc;
    reqKindE              allocKind;
    logic                 free;
    logic [IDX_MAX_W-1:0] freeIdx;
  } tblStrobeS;

endpackage

// File: rtl/missTable.sv
module missTable
  import missAdmitPkg::*;
#(
  parameter int NUM_ENTRIES = 3,
  parameter int IDXW        = 2,
  parameter int CNTW        = 2,
  parameter int MAX_DISCARD = 1,
  parameter int MAX_ALWAYS  = 1,
  parameter int MAX_IFETCH  = 1,
  parameter int MAX_STORE   = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  tblStrobeS                     strobe,
  output logic [CNTW-1:0]               totalCnt,
  output logic [NUM_SRC-1:0][CNTW-1:0]  srcCnt,
  output logic [NUM_KIND-1:0][CNTW-1:0] kindCnt,
  output logic                          hasFree,
  output logic [IDXW-1:0]               freeIdx
);

  logic [NUM_ENTRIES-1:0] entValid;
  logic [1:0]             entSrc  [NUM_ENTRIES];
  reqKindE                entKind [NUM_ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        entValid[e] <= 1'b0;
        entSrc[e]   <= '0;
        entKind[e]  <= KIND_SHARED;
      end
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (strobe.alloc && strobe.allocIdx == IDX_MAX_W'(e)) begin
          entValid[e] <= 1'b1;
          entSrc[e]   <= strobe.allocSrc;
          entKind[e]  <= strobe.allocKind;
        end else if (strobe.free && strobe.freeIdx == IDX_MAX_W'(e)) begin
          entValid[e] <= 1'b0;
        end
      end
    end
  end

  // occupancy counts and lowest free slot
  always_comb begin
    totalCnt = '0;
    srcCnt   = '0;
    kindCnt  = '0;
    hasFree  = 1'b0;
    freeIdx  = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (entValid[e]) begin
        totalCnt            = totalCnt + 1'b1;
        srcCnt[entSrc[e]]   = srcCnt[entSrc[e]] + 1'b1;
        kindCnt[entKind[e]] = kindCnt[entKind[e]] + 1'b1;
      end else begin
        hasFree = 1'b1;
        freeIdx = IDXW'(e);
      end
    end
  end

  p_total_cap_r1: assert property (@(posedge clk) disable iff (!rstN)
    totalCnt <= CNTW'(NUM_ENTRIES));

  p_discard_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    kindCnt[KIND_DISCARD] <= CNTW'(MAX_DISCARD));

  p_always_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    kindCnt[KIND_ALWAYS] <= CNTW'(MAX_ALWAYS));

  p_src_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    srcCnt[SRC_IFETCH] <= CNTW'(MAX_IFETCH) && srcCnt[SRC_STORE] <= CNTW'(MAX_STORE));

  p_nc_alone_r6: assert property (@(posedge clk) disable iff (!rstN)
    kindCnt[KIND_NCSINGLE] != '0 |-> totalCnt == CNTW'(1));

  p_alloc_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |-> !entValid[strobe.allocIdx]);

  p_free_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.free && !(strobe.alloc && strobe.allocIdx == strobe.freeIdx)
      |=> !entValid[$past(strobe.freeIdx)]);

endmodule

// File: rtl/admitCtl.sv
module admitCtl
  import missAdmitPkg::*;
#(
  parameter int NUM_ENTRIES = 3,
  parameter int IDXW        = 2,
  parameter int CNTW        = 2,
  parameter int MAX_RDSO    = 3,
  parameter int MAX_DISCARD = 1,
  parameter int MAX_ALWAYS  = 1,
  parameter int MAX_IFETCH  = 1,
  parameter int MAX_LOAD    = 3,
  parameter int MAX_STORE   = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SRC-1:0]            reqValid,
  input  logic [NUM_SRC-1:0][2:0]       reqKind,
  input  logic                          cplValid,
  input  logic [IDXW-1:0]               cplIdx,
  input  logic [CNTW-1:0]               totalCnt,
  input  logic [NUM_SRC-1:0][CNTW-1:0]  srcCnt,
  input  logic [NUM_KIND-1:0][CNTW-1:0] kindCnt,
  input  logic                          hasFree,
  input  logic [IDXW-1:0]               freeIdx,
  output tblStrobeS                     strobe,
  output logic [NUM_SRC-1:0]            grant
);

  logic [NUM_SRC-1:0] eligible;
  logic [1:0]         selSrc;
  logic               ncBusy;
  logic [CNTW:0]      rdsoCnt;

  assign ncBusy  = kindCnt[KIND_NCSINGLE] != '0;
  assign rdsoCnt = (CNTW+1)'(kindCnt[KIND_SHARED]) + (CNTW+1)'(kindCnt[KIND_OWN]);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int SRC_LIM = (s == SRC_IFETCH) ? MAX_IFETCH :
                             (s == SRC_LOAD)   ? MAX_LOAD   : MAX_STORE;
    logic kindOk;
    always_comb begin
      case (reqKind[s])
        KIND_SHARED, KIND_OWN: kindOk = rdsoCnt < (CNTW+1)'(MAX_RDSO);
        KIND_DISCARD:          kindOk = kindCnt[KIND_DISCARD] < CNTW'(MAX_DISCARD);
        KIND_ALWAYS:           kindOk = kindCnt[KIND_ALWAYS] < CNTW'(MAX_ALWAYS);
        KIND_NCSINGLE:         kindOk = totalCnt == '0;
        default:               kindOk = 1'b0;
      endcase
    end
    assign eligible[s] = reqValid[s] && kindOk && hasFree && !ncBusy &&
                         (srcCnt[s] < CNTW'(SRC_LIM));
  end

  // lowest bit (instruction fetch) has priority
  assign grant = eligible & (~eligible + 1'b1);

  always_comb begin
    selSrc = '0;
    for (int s = NUM_SRC - 1; s >= 0; s--)
      if (eligible[s]) selSrc = 2'(s);
  end

  always_comb begin
    strobe           = '0;
    strobe.alloc     = |eligible;
    strobe.allocIdx  = IDX_MAX_W'(freeIdx);
    strobe.allocSrc  = selSrc;
    strobe.allocKind = reqKindE'(reqKind[selSrc]);
    strobe.free      = cplValid;
    strobe.freeIdx   = IDX_MAX_W'(cplIdx);
  end

  p_one_grant_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  p_grant_room_r1: assert property (@(posedge clk) disable iff (!rstN)
    (|grant) |-> totalCnt < CNTW'(NUM_ENTRIES));

  p_reserved_r10: assert property (@(posedge clk) disable iff (!rstN)
    (|grant) |-> reqKind[selSrc] <= 3'd4);

  p_grant_requested_r11: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~reqValid) == '0);

endmodule

// File: rtl/readMissAdmit.sv
module readMissAdmit
  import missAdmitPkg::*;
#(
  parameter int NUM_ENTRIES = 3,
  parameter int MAX_RDSO    = 3,
  parameter int MAX_DISCARD = 1,
  parameter int MAX_ALWAYS  = 1,
  parameter int MAX_IFETCH  = 1,
  parameter int MAX_LOAD    = 3,
  parameter int MAX_STORE   = 1,
  localparam int IDXW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int CNTW = $clog2(NUM_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        reqValid,
  input  logic [8:0]        reqKind,
  input  logic              cplValid,
  input  logic [IDXW-1:0]   cplIdx,
  output logic [2:0]        grant,
  output logic [IDXW-1:0]   grantIdx
);

  tblStrobeS                     strobe;
  logic [NUM_SRC-1:0][2:0]       kindArr;
  logic [CNTW-1:0]               totalCnt;
  logic [NUM_SRC-1:0][CNTW-1:0]  srcCnt;
  logic [NUM_KIND-1:0][CNTW-1:0] kindCnt;
  logic                          hasFree;
  logic [IDXW-1:0]               freeIdx;

  assign kindArr  = reqKind;
  assign grantIdx = freeIdx;

  admitCtl #(
    .NUM_ENTRIES(NUM_ENTRIES), .IDXW(IDXW), .CNTW(CNTW), .MAX_RDSO(MAX_RDSO),
    .MAX_DISCARD(MAX_DISCARD), .MAX_ALWAYS(MAX_ALWAYS), .MAX_IFETCH(MAX_IFETCH),
    .MAX_LOAD(MAX_LOAD), .MAX_STORE(MAX_STORE)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(kindArr),
    .cplValid(cplValid), .cplIdx(cplIdx), .totalCnt(totalCnt), .srcCnt(srcCnt),
    .kindCnt(kindCnt), .hasFree(hasFree), .freeIdx(freeIdx),
    .strobe(strobe), .grant(grant)
  );

  missTable #(
    .NUM_ENTRIES(NUM_ENTRIES), .IDXW(IDXW), .CNTW(CNTW), .MAX_DISCARD(MAX_DISCARD),
    .MAX_ALWAYS(MAX_ALWAYS), .MAX_IFETCH(MAX_IFETCH), .MAX_STORE(MAX_STORE)
  ) u_tbl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .totalCnt(totalCnt), .srcCnt(srcCnt),
    .kindCnt(kindCnt), .hasFree(hasFree), .freeIdx(freeIdx)
  );

endmodule

// File: tb/readMissAdmit_test.sv
module readMissAdmit_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] reqValid;
  logic [8:0] reqKind;
  logic       cplValid;
  logic [1:0] cplIdx;
  logic [2:0] grant;
  logic [1:0] grantIdx;

  int nChecks = 0;
  int nFail   = 0;

  localparam logic [2:0] SH = 3'd0, OW = 3'd1, DI = 3'd2, AL = 3'd3, NC = 3'd4;
  localparam int IF = 0, LD = 1, ST = 2;

  always #10 clk = ~clk;

  readMissAdmit uut (.*);

  // drive at negedge, check before posedge, clear at next negedge
  task automatic step(input logic [2:0] v, input logic [8:0] k, input logic cv,
                      input logic [1:0] ci, input logic [2:0] expG,
                      input logic [1:0] expI, input string req);
    reqValid = v; reqKind = k; cplValid = cv; cplIdx = ci;
    #2;
    nChecks++;
    if (grant !== expG || (expG != 3'b000 && grantIdx !== expI)) begin
      nFail++;
      $display("FAIL %s: grant=%b idx=%0d expected grant=%b idx=%0d",
               req, grant, grantIdx, expG, expI);
    end
    @(negedge clk);
    reqValid = '0; cplValid = 1'b0;
  endtask

  task automatic one(input int src, input logic [2:0] kind, input bit ok,
                     input logic [1:0] idx, input string req);
    step(3'(1 << src), 9'(kind) << (3 * src), 1'b0, 2'd0,
         ok ? 3'(1 << src) : 3'b000, idx, req);
  endtask

  task automatic done(input logic [1:0] idx, input string req);
    step(3'b000, 9'd0, 1'b1, idx, 3'b000, 2'd0, req);
  endtask

  task automatic doReset();
    rstN = 1'b0; reqValid = '0; reqKind = '0; cplValid = 1'b0; cplIdx = '0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    step(3'b000, 9'd0, 1'b0, 2'd0, 3'b000, 2'd0, "R11 idle no grant");
    one(IF, SH, 1, 2'd0, "R11 first grant takes entry 0");
  endtask

  task automatic testSharedCap();
    doReset();
    one(LD, SH, 1, 2'd0, "R2 load shared");
    one(LD, OW, 1, 2'd1, "R2 load own");
    one(LD, SH, 1, 2'd2, "R2 third shared/own");
    one(LD, SH, 0, 2'd0, "R1 fourth stalled when full");
    one(IF, OW, 0, 2'd0, "R1 fetch stalled when full");
    done(2'd1, "R8 complete entry 1");
    one(LD, OW, 1, 2'd1, "R8 freed entry 1 reused");
  endtask

  task automatic testDiscard();
    doReset();
    one(LD, DI, 1, 2'd0, "R3 first discard");
    one(LD, DI, 0, 2'd0, "R3 second discard stalled");
    one(IF, DI, 0, 2'd0, "R3 fetch discard stalled");
    one(LD, SH, 1, 2'd1, "R3 shared still admitted");
    done(2'd0, "R3 complete discard");
    one(LD, DI, 1, 2'd0, "R3 discard after free");
  endtask

  task automatic testAlways();
    doReset();
    one(ST, AL, 1, 2'd0, "R4 first shared-always");
    one(LD, AL, 0, 2'd0, "R4 second shared-always stalled");
    one(LD, OW, 1, 2'd1, "R4 own still admitted");
  endtask

  task automatic testSources();
    doReset();
    one(IF, SH, 1, 2'd0, "R5 fetch one");
    one(IF, OW, 0, 2'd0, "R5 second fetch stalled");
    one(ST, OW, 1, 2'd1, "R5 store one");
    one(ST, SH, 0, 2'd0, "R5 second store stalled");
    one(LD, SH, 1, 2'd2, "R5 load alongside");
    done(2'd0, "R5 free fetch entry");
    one(IF, SH, 1, 2'd0, "R5 fetch after free");
  endtask

  task automatic testNcSingle();
    doReset();
    one(LD, NC, 1, 2'd0, "R6 nc single on empty");
    one(LD, SH, 0, 2'd0, "R6 load blocked by nc");
    one(IF, SH, 0, 2'd0, "R6 fetch blocked by nc");
    one(ST, NC, 0, 2'd0, "R6 second nc blocked");
    done(2'd0, "R6 complete nc");
    one(LD, SH, 1, 2'd0, "R6 load after nc done");
    one(ST, NC, 0, 2'd0, "R6 nc blocked by cacheable");
  endtask

  task automatic testPriority();
    doReset();
    step(3'b111, {SH, SH, SH}, 1'b0, 2'd0, 3'b001, 2'd0, "R7 fetch wins");
    step(3'b110, {SH, SH, SH}, 1'b0, 2'd0, 3'b010, 2'd1, "R7 load over store");
    step(3'b100, {SH, SH, SH}, 1'b0, 2'd0, 3'b100, 2'd2, "R7 store last");
    doReset();
    one(IF, SH, 1, 2'd0, "R7 fetch occupies its slot");
    step(3'b101, {SH, SH, SH}, 1'b0, 2'd0, 3'b100, 2'd1, "R7 ineligible fetch passed over");
    one(LD, DI, 1, 2'd2, "R7 load discard");
    done(2'd1, "R7 free store entry");
    step(3'b110, {OW, DI, SH}, 1'b0, 2'd0, 3'b100, 2'd1, "R7 ineligible load passed over");
  endtask

  task automatic testSameCycle();
    doReset();
    one(LD, SH, 1, 2'd0, "R9 fill 0");
    one(LD, SH, 1, 2'd1, "R9 fill 1");
    one(LD, SH, 1, 2'd2, "R9 fill 2");
    step(3'b010, 9'(SH) << 3, 1'b1, 2'd2, 3'b000, 2'd0, "R9 full table, freeing cycle stalls");
    one(LD, OW, 1, 2'd2, "R9 freed slot usable next cycle");
    doReset();
    one(LD, SH, 1, 2'd0, "R9 part fill 0");
    one(LD, SH, 1, 2'd1, "R9 part fill 1");
    step(3'b010, 9'(SH) << 3, 1'b1, 2'd0, 3'b010, 2'd2, "R9 grant and free together");
    one(LD, SH, 1, 2'd0, "R9 freed entry 0 reused");
    one(LD, SH, 0, 2'd0, "R9 both effects applied, table full");
  endtask

  task automatic testIgnore();
    doReset();
    one(LD, SH, 1, 2'd0, "R8 fill 0");
    done(2'd2, "R8 complete empty entry");
    one(LD, SH, 1, 2'd1, "R8 entry 0 kept after empty completion");
    one(LD, SH, 1, 2'd2, "R8 fill 2");
    one(LD, SH, 0, 2'd0, "R8 table full after empty completion");
  endtask

  task automatic testReserved();
    doReset();
    one(LD, 3'd5, 0, 2'd0, "R10 kind 5 refused");
    one(LD, 3'd7, 0, 2'd0, "R10 kind 7 refused");
    one(IF, 3'd6, 0, 2'd0, "R10 kind 6 refused");
    one(IF, SH, 1, 2'd0, "R10 table untouched by reserved");
  endtask

  initial begin
    #(20 * 100000);
    nFail++;
    nChecks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = '0; reqKind = '0; cplValid = 1'b0; cplIdx = '0;
    @(negedge clk);
    testReset();
    testSharedCap();
    testDiscard();
    testAlways();
    testSources();
    testNcSingle();
    testPriority();
    testSameCycle();
    testIgnore();
    testReserved();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule